// File: doc/BRIEF.md
# Variable-Width CRC32C Accumulator

This block folds one source operand into a running 32-bit CRC using the Castagnoli generator, following the semantics of a processor CRC-accumulate operation. The caller supplies the current CRC, a 64-bit source bus and a width code choosing 8, 16, 32 or 64 source bits. The block returns the new CRC and a 64-bit destination word whose upper half is either cleared or carried through from a separate input.

The mathematical form is: reflect the source across its own width and the CRC across 32 bits, align and XOR them into a (W+32)-bit dividend, take the modulo-2 remainder by 0x11EDC6F41, and reflect that remainder. The datapath uses the equivalent reflected-register form. Each cycle it consumes `CHUNK` source bits, starting with the least significant bit, so the latency depends only on the width code. Picking the initial value and applying the final inversion are left to the caller.

Top module: `crc32c_accum`

## Requirements
- R1: With width code 2'b00, the result equals the reflected CRC32C update of source byte [7:0] (reflected generator 0x82F63B78, `crc = (crc >> 8) ^ T[(crc ^ byte) & 0xFF]`).
- R2: With width code 2'b01, the result equals that byte update applied to source bytes 0 then 1.
- R3: With width code 2'b10, the result equals that byte update applied to source bytes 0 through 3, lowest byte first.
- R4: With width code 2'b11, the result equals that byte update applied to all eight source bytes, lowest byte first. Starting from 0xFFFFFFFF, feeding the ASCII string "123456789" and inverting the result gives 0xE3069283.
- R5: Source bits above the selected width have no effect on the result.
- R6: With width code 2'b11, `dst_out[63:32]` is zero whenever `done` is high.
- R7: With width code 2'b00 or 2'b10, `req_wide_dst` = 1 clears `dst_out[63:32]` and `req_wide_dst` = 0 copies `dst_hi_in` there. With width code 2'b01, `dst_hi_in` is always copied. In every case `dst_out[31:0]` equals `crc_out`.
- R8: `done` is a single-cycle pulse that comes exactly (8 << width code) / CHUNK clock edges after the edge that accepts the request.
- R9: A request is accepted only when `req_valid` is high and `busy` is low. A request presented while `busy` is high is ignored and produces no result.
- R10: After `done`, `crc_out` and `dst_out` hold their values until the next accepted request.
- R11: After reset, `busy` and `done` are low and `crc_out` and `dst_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_width | input | 2 | Source width code: 00=8, 01=16, 10=32, 11=64 bits |
| req_wide_dst | input | 1 | Clear the upper destination half (8/32-bit sources only) |
| crc_in | input | 32 | Running CRC before the update |
| src_in | input | 64 | Source operand, least significant bits used first |
| dst_hi_in | input | 32 | Upper destination half to carry through when not cleared |
| busy | output | 1 | Update in progress; new requests ignored |
| done | output | 1 | One-cycle result-ready pulse |
| crc_out | output | 32 | Updated CRC |
| dst_out | output | 64 | Destination word: upper half per R6/R7, lower half the CRC |

## Verification
The bench chains a 64-bit and an 8-bit update over a well-known check string. A design that reflected the wrong operand, or consumed bytes from the top end, would miss the standard check value. It repeats each width with random garbage above the selected bits: a design that masked or counted badly would then give a different CRC for the same low bits. It sweeps the destination-width option across all four width codes, which catches a 16-bit source wrongly clearing the upper half or a 64-bit source copying it. It also fires a second request into a busy unit and checks the completion timing per width. A design that restarted or corrupted the running state would emit an unexpected result, and one with an off-by-one counter would pulse `done` on the wrong edge.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

   // Generator including the x^32 term.
   localparam logic [32:0] CRC32C_GEN = 33'h1_1EDC_6F41;

   function automatic logic [31:0] reflect32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // Reflected generator used by the LSB-first shift register form.
   localparam logic [31:0] CRC32C_POLY_REFL = reflect32(CRC32C_GEN[31:0]);

   localparam int unsigned SRC_BUS_W = 64;

   typedef enum logic [1:0] {
      SRC_W8  = 2'b00,
      SRC_W16 = 2'b01,
      SRC_W32 = 2'b10,
      SRC_W64 = 2'b11
   } src_width_e;

   function automatic int unsigned width_bits(input src_width_e w);
      return 32'd8 << w;
   endfunction

endpackage

// File: rtl/crc32c_step.sv
// Folds CHUNK source bits (LSB first) into the reflected CRC register.
module crc32c_step
   import crc32c_pkg::*;
#(
   parameter int unsigned CHUNK = 8
) (
   input  logic [31:0]      crc_i,
   input  logic [CHUNK-1:0] data_i,
   output logic [31:0]      crc_o
);

   generate
      if (CHUNK == 1) begin : g_single
         logic fb;
         assign fb    = crc_i[0] ^ data_i[0];
         assign crc_o = {1'b0, crc_i[31:1]} ^ (fb ? CRC32C_POLY_REFL : 32'h0);
      end else begin : g_multi
         always_comb begin
            logic [31:0] c;
            logic        fb;
            c = crc_i;
            for (int i = 0; i < CHUNK; i++) begin
               fb = c[0] ^ data_i[i];
               c  = {1'b0, c[31:1]} ^ (fb ? CRC32C_POLY_REFL : 32'h0);
            end
            crc_o = c;
         end
      end
   endgenerate

endmodule

// File: rtl/crc32c_seq.sv
// Iteration counter: loaded with the chunk count on start.
module crc32c_seq
   import crc32c_pkg::*;
#(
   parameter int unsigned CHUNK = 8,
   parameter int unsigned CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  src_width_e width,
   output logic       busy,
   output logic       last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CNT_W'(width_bits(width) / CHUNK);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/crc32c_hi_sel.sv
// Chooses the upper destination half at request time.
module crc32c_hi_sel
   import crc32c_pkg::*;
(
   input  src_width_e  width,
   input  logic        wide_dst,
   input  logic [31:0] hi_i,
   output logic [31:0] hi_o
);

   logic clear;

   always_comb begin
      unique case (width)
         SRC_W64: clear = 1'b1;
         SRC_W16: clear = 1'b0;
         default: clear = wide_dst;
      endcase
      hi_o = clear ? 32'h0 : hi_i;
   end

endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum
   import crc32c_pkg::*;
#(
   parameter int unsigned CHUNK = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_width,
   input  logic        req_wide_dst,
   input  logic [31:0] crc_in,
   input  logic [63:0] src_in,
   input  logic [31:0] dst_hi_in,
   output logic        busy,
   output logic        done,
   output logic [31:0] crc_out,
   output logic [63:0] dst_out
);

   localparam int unsigned MAX_ITER = SRC_BUS_W / CHUNK;
   localparam int unsigned CNT_W    = $clog2(MAX_ITER + 1);

   generate
      if (!(CHUNK == 1 || CHUNK == 2 || CHUNK == 4 || CHUNK == 8)) begin : g_bad_chunk
         $error("crc32c_accum: CHUNK must be 1, 2, 4 or 8");
      end
   endgenerate

   src_width_e  wsel;
   logic        accept;
   logic        last;
   logic [31:0] crc_q;
   logic [31:0] crc_nxt;
   logic [31:0] hi_q;
   logic [31:0] hi_nxt;
   logic [63:0] sh_q;
   logic        done_q;

   assign wsel   = src_width_e'(req_width);
   assign accept = req_valid && !busy;

   crc32c_seq #(
      .CHUNK (CHUNK),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .width (wsel),
      .busy  (busy),
      .last  (last)
   );

   crc32c_step #(
      .CHUNK (CHUNK)
   ) u_step (
      .crc_i  (crc_q),
      .data_i (sh_q[CHUNK-1:0]),
      .crc_o  (crc_nxt)
   );

   crc32c_hi_sel u_hi_sel (
      .width    (wsel),
      .wide_dst (req_wide_dst),
      .hi_i     (dst_hi_in),
      .hi_o     (hi_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q  <= '0;
         sh_q   <= '0;
         hi_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy && last;
         if (accept) begin
            crc_q <= crc_in;
            sh_q  <= src_in;
            hi_q  <= hi_nxt;
         end else if (busy) begin
            crc_q <= crc_nxt;
            sh_q  <= sh_q >> CHUNK;
         end
      end
   end

   assign done    = done_q;
   assign crc_out = crc_q;
   assign dst_out = {hi_q, crc_q};

endmodule

// File: rtl/crc32c_accum_chk.sv
module crc32c_accum_chk
#(
   parameter int unsigned CHUNK = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  req_width,
   input logic        busy,
   input logic        done,
   input logic [31:0] crc_out,
   input logic [63:0] dst_out
);

   logic [1:0] acc_w;
   logic [7:0] exp_n;
   logic [7:0] elapsed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_w   <= '0;
         exp_n   <= '0;
         elapsed <= '0;
      end else if (req_valid && !busy) begin
         acc_w   <= req_width;
         exp_n   <= 8'((32'd8 << req_width) / CHUNK);
         elapsed <= 8'd1;
      end else if (busy) begin
         elapsed <= elapsed + 8'd1;
      end
   end

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(elapsed) == exp_n));

   a_r9_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   a_r6_w64_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && acc_w == 2'b11) |-> (dst_out[63:32] == 32'h0));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> ($stable(crc_out) && $stable(dst_out)));

   a_r7_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (dst_out[31:0] == crc_out));

endmodule

bind crc32c_accum crc32c_accum_chk #(.CHUNK(CHUNK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_width (req_width),
   .busy      (busy),
   .done      (done),
   .crc_out   (crc_out),
   .dst_out   (dst_out)
);

// File: tb/crc32c_accum_bench.sv
module crc32c_accum_bench;

   localparam int CHUNK   = 8;
   localparam int WD_LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [1:0]  req_width;
   logic        req_wide_dst;
   logic [31:0] crc_in;
   logic [63:0] src_in;
   logic [31:0] dst_hi_in;
   logic        busy;
   logic        done;
   logic [31:0] crc_out;
   logic [63:0] dst_out;

   always #10 clk = ~clk;   // 50 MHz

   crc32c_accum #(.CHUNK(CHUNK)) u_crc32c_accum (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_width    (req_width),
      .req_wide_dst (req_wide_dst),
      .crc_in       (crc_in),
      .src_in       (src_in),
      .dst_hi_in    (dst_hi_in),
      .busy         (busy),
      .done         (done),
      .crc_out      (crc_out),
      .dst_out      (dst_out)
   );

   typedef struct {
      logic [31:0] crc;
      logic [63:0] dst;
      int          due;
      int          w;
   } exp_t;

   exp_t        sb[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] last_crc = '0;
   logic [63:0] last_dst = '0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] tbl_entry(input logic [7:0] idx);
      logic [31:0] c;
      c = {24'h0, idx};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
      return c;
   endfunction

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [63:0] s, input int nbytes);
      for (int b = 0; b < nbytes; b++) c = (c >> 8) ^ tbl_entry(c[7:0] ^ s[8*b +: 8]);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic string crc_tag(input int w);
      case (w)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         default: return "R4";
      endcase
   endfunction

   // Driver: waits for idle, presents one request, queues the expectation.
   task automatic issue(input logic [1:0] w, input logic wide, input logic [31:0] c,
                        input logic [63:0] s, input logic [31:0] hi);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid    = 1'b1;
      req_width    = w;
      req_wide_dst = wide;
      crc_in       = c;
      src_in       = s;
      dst_hi_in    = hi;
      e.crc = ref_crc(c, s, 1 << w);
      e.dst = {((w == 2'b11) || (wide && w != 2'b01)) ? 32'h0 : hi, e.crc};
      e.due = cyc + 1 + ((8 << w) / CHUNK);
      e.w   = int'(w);
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pops the scoreboard on every done pulse.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9", "done without accepted request", {32'h0, crc_out}, 64'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(crc_out == e.crc, crc_tag(e.w), "crc_out", {32'h0, crc_out}, {32'h0, e.crc});
            check(dst_out == e.dst, (e.w == 3) ? "R6" : "R7", "dst_out", dst_out, e.dst);
            check(cyc == e.due, "R8", "done edge", 64'(cyc), 64'(e.due));
            last_crc = crc_out;
            last_dst = dst_out;
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      if (cyc == WD_LIMIT) begin
         check(1'b0, "WDOG", "run did not finish", 64'(cyc), 64'(WD_LIMIT));
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] c2;
      logic [31:0] keep;
      logic [63:0] s;
      rst_n        = 1'b0;
      req_valid    = 1'b0;
      req_width    = 2'b00;
      req_wide_dst = 1'b0;
      crc_in       = '0;
      src_in       = '0;
      dst_hi_in    = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(busy == 1'b0, "R11", "busy after reset", 64'(busy), 64'h0);
      check(done == 1'b0, "R11", "done after reset", 64'(done), 64'h0);
      check(crc_out == 32'h0, "R11", "crc_out after reset", {32'h0, crc_out}, 64'h0);
      check(dst_out == 64'h0, "R11", "dst_out after reset", dst_out, 64'h0);
      rst_n = 1'b1;

      // R4 known check value over "123456789"
      issue(2'b11, 1'b0, 32'hFFFF_FFFF, 64'h3837_3635_3433_3231, 32'hDEAD_BEEF);
      c2 = ref_crc(32'hFFFF_FFFF, 64'h3837_3635_3433_3231, 8);
      issue(2'b00, 1'b1, c2, 64'hAAAA_AAAA_AAAA_AA39, 32'h1234_5678);
      drain();
      check((last_crc ^ 32'hFFFF_FFFF) == 32'hE306_9283, "R4", "check string CRC",
            {32'h0, last_crc ^ 32'hFFFF_FFFF}, 64'hE306_9283);

      // R1..R4, R6, R7, R8: every width, both destination options, back-to-back
      for (int w = 0; w < 4; w++) begin
         for (int k = 0; k < 4; k++) begin
            issue(2'(w), 1'(k), $urandom(), {$urandom(), $urandom()}, $urandom());
         end
      end
      drain();

      // R5: garbage above the selected width leaves the result unchanged
      for (int w = 0; w < 3; w++) begin
         s = {$urandom(), $urandom()};
         c2 = $urandom();
         issue(2'(w), 1'b0, c2, s & ((64'h1 << (8 << w)) - 1), 32'h0);
         drain();
         keep = last_crc;
         issue(2'(w), 1'b0, c2, s | ~((64'h1 << (8 << w)) - 1), 32'h0);
         drain();
         check(last_crc == keep, "R5", "upper source bits changed result",
               {32'h0, last_crc}, {32'h0, keep});
      end

      // R9: request while busy is ignored
      issue(2'b11, 1'b0, 32'h0BAD_F00D, 64'h0123_4567_89AB_CDEF, 32'h5555_AAAA);
      check(busy == 1'b1, "R9", "busy during update", 64'(busy), 64'h1);
      req_valid = 1'b1;
      req_width = 2'b00;
      crc_in    = 32'hFFFF_0000;
      src_in    = 64'hFF;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      drain();
      repeat (4) @(negedge clk);
      check(crc_out == ref_crc(32'h0BAD_F00D, 64'h0123_4567_89AB_CDEF, 8), "R9",
            "result after ignored request", {32'h0, crc_out},
            {32'h0, ref_crc(32'h0BAD_F00D, 64'h0123_4567_89AB_CDEF, 8)});

      // R10: outputs hold while idle
      issue(2'b10, 1'b0, 32'h1357_9BDF, 64'hFFFF_FFFF_0F1E_2D3C, 32'hCAFE_F00D);
      drain();
      repeat (6) @(negedge clk);
      check(crc_out == last_crc, "R10", "crc_out held", {32'h0, crc_out}, {32'h0, last_crc});
      check(dst_out == last_dst, "R10", "dst_out held", dst_out, last_dst);

      summary();
      $finish;
   end

endmodule